// File: doc/BRIEF.md
# Stepped Second-Order Integrator Datapath

This block integrates a second-order differential equation by forward stepping, using a multicycle datapath and a small control machine. A single-cycle `start` pulse in the idle state captures the initial position `x`, the value `y`, its derivative `u`, the step size `dx` and the loop bound. The block then repeats a fixed recurrence. Each pass advances `x` by `dx`. It moves `y` along the old `u` and updates `u` with the cubic-damping term `u - 3*x*u*dx - 3*y*dx`. The loop ends when the position has reached the bound. The final `y` is then presented together with a one-cycle `done` pulse.

Every pass takes exactly four clock cycles. Four multipliers and two add/subtract/compare units are shared across the eleven operations of one pass. The products are formed in the first two cycles, and the two subtractions that finish `u` take one cycle each. All values are W-bit two's-complement integers. Every product and sum is truncated to W bits, so results wrap modulo 2^W.

Top module: `diffeq_stepper`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `done` is 0 and `y_out` is 0.
- R2: A `start` high in the idle state captures `x_in`, `y_in`, `u_in`, `dx_in` and `bound_in` at that clock edge and begins the first pass.
- R3: Each pass occupies exactly four clock cycles. With N passes, `done` is high in exactly the cycle that follows the 4N-th rising edge after the accepting edge.
- R4: Each pass replaces x with x + dx.
- R5: Each pass replaces u with u - (3*x)*(u*dx) - (3*y)*dx, computed from the values at the start of the pass.
- R6: Each pass replaces y with y + u*dx, using the u from the start of the pass.
- R7: The loop flag is the signed comparison x < bound on the x from the start of the pass. The loop repeats while the flag is 1 and stops after the pass where it is 0. At least one pass always runs.
- R8: `done` is high for a single cycle. `y_out` holds the final y from that cycle until the next accepted `start`.
- R9: `start` and the operand inputs are ignored while a computation is in progress.
- R10: Every product and sum is truncated to W bits (two's-complement wraparound), and the constant 3 enters as a multiplier operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation (only honoured when idle) |
| x_in | input | W | Initial position |
| y_in | input | W | Initial y |
| u_in | input | W | Initial derivative u |
| dx_in | input | W | Step size |
| bound_in | input | W | Position bound that ends the loop |
| done | output | 1 | One-cycle completion pulse |
| y_out | output | W | Final y, held after completion |

## Verification
A wrong step register or operand selection shows up in `y_out` as a value that differs from the modelled recurrence at the `done` pulse. A corrupted `x`, bound or flag shows up earlier and more plainly: `done` rises in a cycle other than the multiple of four predicted by the pass count. The bench compares `done` on every cycle after each accepted start against the model, so a misplaced pass boundary is reported within one cycle of the expected pulse. Runs with a single pass, two passes, many wrapping passes and negative operands are compared, and so is a run where `start` is asserted in the middle with different operands.

// File: rtl/diffeq_stepper.sv
module diffeq_stepper #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic signed [W-1:0] x_in,
  input  logic signed [W-1:0] y_in,
  input  logic signed [W-1:0] u_in,
  input  logic signed [W-1:0] dx_in,
  input  logic signed [W-1:0] bound_in,
  output logic                done,
  output logic signed [W-1:0] y_out
);
  localparam int NMUL = 4;
  localparam int NALU = 2;
  localparam logic signed [W-1:0] THREE = W'(3);

  typedef enum logic [2:0] {IDLE, S1, S2, S3, S4, FIN} st_t;
  typedef enum logic [1:0] {OP_ADD, OP_SUB, OP_LT} op_t;

  st_t st;
  logic signed [W-1:0] x, y, u, dx, bnd;
  logic signed [W-1:0] t_a, t_b, t_c, t_d, xn, p_a, p_b, yn, dif;
  logic go;

  logic signed [W-1:0] ma [NMUL];
  logic signed [W-1:0] mb [NMUL];
  logic signed [W-1:0] mp [NMUL];
  logic signed [W-1:0] aa [NALU];
  logic signed [W-1:0] ab [NALU];
  logic signed [W-1:0] ar [NALU];
  op_t                 aop [NALU];

  for (genvar i = 0; i < NMUL; i++) begin : g_mul
    assign mp[i] = ma[i] * mb[i];
  end

  for (genvar i = 0; i < NALU; i++) begin : g_alu
    always_comb begin
      case (aop[i])
        OP_ADD:  ar[i] = aa[i] + ab[i];
        OP_SUB:  ar[i] = aa[i] - ab[i];
        default: ar[i] = (aa[i] < ab[i]) ? W'(1) : W'(0);
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < NMUL; i++) begin
      ma[i] = '0;
      mb[i] = '0;
    end
    for (int i = 0; i < NALU; i++) begin
      aa[i]  = '0;
      ab[i]  = '0;
      aop[i] = OP_ADD;
    end
    case (st)
      S1: begin
        ma[0] = THREE; mb[0] = x;
        ma[1] = u;     mb[1] = dx;
        ma[2] = THREE; mb[2] = y;
        ma[3] = u;     mb[3] = dx;
        aa[0] = x;     ab[0] = dx;
      end
      S2: begin
        ma[0] = t_a;   mb[0] = t_b;
        ma[1] = t_c;   mb[1] = dx;
        aa[0] = y;     ab[0] = t_d;
        aa[1] = x;     ab[1] = bnd;  aop[1] = OP_LT;
      end
      S3: begin
        aa[0] = u;     ab[0] = p_a;  aop[0] = OP_SUB;
      end
      S4: begin
        aa[0] = dif;   ab[0] = p_b;  aop[0] = OP_SUB;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      {x, y, u, dx, bnd} <= '0;
      {t_a, t_b, t_c, t_d, xn, p_a, p_b, yn, dif} <= '0;
      go <= 1'b0;
    end else begin
      case (st)
        IDLE: if (start) begin
          x <= x_in; y <= y_in; u <= u_in; dx <= dx_in; bnd <= bound_in;
          st <= S1;
        end
        S1: begin
          t_a <= mp[0]; t_b <= mp[1]; t_c <= mp[2]; t_d <= mp[3];
          xn  <= ar[0];
          st  <= S2;
        end
        S2: begin
          p_a <= mp[0]; p_b <= mp[1];
          yn  <= ar[0];
          go  <= |ar[1];
          st  <= S3;
        end
        S3: begin
          dif <= ar[0];
          st  <= S4;
        end
        S4: begin
          u  <= ar[0];
          x  <= xn;
          y  <= yn;
          st <= go ? S1 : FIN;
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign done  = (st == FIN);
  assign y_out = y;
endmodule

// File: rtl/diffeq_stepper_chk.sv
module diffeq_stepper_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         done,
  input logic [2:0]   st,
  input logic [W-1:0] y_out
);
  localparam logic [2:0] C_IDLE = 3'd0, C_S1 = 3'd1, C_S2 = 3'd2,
                         C_S3 = 3'd3, C_S4 = 3'd4, C_FIN = 3'd5;

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r3_step_order: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_S1) |=> (st == C_S2));

  a_r3_step_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_S2) |=> (st == C_S3));

  a_r3_step_last: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_S3) |=> (st == C_S4));

  a_r7_loop_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_S4) |=> (st == C_S1 || st == C_FIN));

  a_r2_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_IDLE && start) |=> (st == C_S1));

  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (st != C_IDLE && st != C_S4 && st != C_FIN) |=> (st != C_IDLE));

  a_r8_y_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_FIN || (st == C_IDLE && !start)) |=> $stable(y_out));
endmodule

bind diffeq_stepper diffeq_stepper_chk #(.W(W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .done  (done),
  .st    (st),
  .y_out (y_out)
);

// File: tb/sim_diffeq_stepper.sv
`timescale 1ns/1ps
module sim_diffeq_stepper;
  localparam int W = 16;
  typedef logic signed [W-1:0] val_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  val_t x_in = '0, y_in = '0, u_in = '0, dx_in = '0, bound_in = '0;
  logic done;
  val_t y_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  diffeq_stepper #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .x_in(x_in), .y_in(y_in), .u_in(u_in), .dx_in(dx_in), .bound_in(bound_in),
    .done(done), .y_out(y_out)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void model(input val_t x0, input val_t y0, input val_t u0v,
                                input val_t dx, input val_t bnd,
                                output val_t yr, output int n);
    val_t x = x0, y = y0, u = u0v, xn, yn, un;
    bit flag;
    n = 0;
    do begin
      flag = (x < bnd);
      xn = x + dx;
      un = u - val_t'(val_t'(val_t'(3) * x) * val_t'(u * dx)) - val_t'(val_t'(val_t'(3) * y) * dx);
      yn = y + val_t'(u * dx);
      x = xn; y = yn; u = un;
      n++;
    end while (flag && n < 5000);
    yr = y;
  endfunction

  task automatic run(input val_t x0, input val_t y0, input val_t u0v,
                     input val_t dx, input val_t bnd, input bit disturb, input string tag);
    val_t exp_y;
    int n;
    model(x0, y0, u0v, dx, bnd, exp_y, n);
    @(negedge clk);
    x_in = x0; y_in = y0; u_in = u0v; dx_in = dx; bound_in = bnd;
    start = 1'b1;
    @(negedge clk);
    for (int k = 0; k <= 4*n + 1; k++) begin
      if (k > 0) @(negedge clk);
      if (disturb && k < 4*n - 1) begin
        start = 1'b1;
        x_in = x0 + 16'sd7; y_in = 16'sd999; u_in = -16'sd3; dx_in = 16'sd2; bound_in = -16'sd100;
      end else begin
        start = 1'b0;
      end
      chk(done == (k == 4*n), {tag, " R3 done timing"}, done, k == 4*n);
      if (k >= 4*n)
        chk(y_out == exp_y, {tag, " R4 R5 R6 R7 R8 R10 final y"}, y_out, exp_y);
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 done in reset", done, 0);
    chk(y_out == 0, "R1 y_out in reset", y_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R1 done after reset", done, 0);
    chk(y_out == 0, "R1 y_out after reset", y_out, 0);
    // R7: bound already reached, single pass
    run(16'sd5, 16'sd3, 16'sd2, 16'sd1, 16'sd5, 1'b0, "single R7");
    // R2: two passes
    run(16'sd0, 16'sd4, -16'sd2, 16'sd1, 16'sd1, 1'b0, "two R2");
    // many passes with wraparound, R10
    run(16'sd0, 16'sd1, 16'sd1, 16'sd1, 16'sd20, 1'b0, "many R10");
    // negative operands, signed compare
    run(-16'sd10, -16'sd7, 16'sd4, 16'sd3, -16'sd2, 1'b0, "signed R7");
    // start held high mid-run with other operands, R9
    run(16'sd1, 16'sd2, 16'sd3, 16'sd2, 16'sd9, 1'b1, "busy R9");
    // R8: y_out held while idle
    begin
      val_t held;
      int n;
      model(16'sd1, 16'sd2, 16'sd3, 16'sd2, 16'sd9, held, n);
      repeat (5) @(negedge clk);
      chk(y_out == held, "R8 y_out held while idle", y_out, held);
      chk(done == 1'b0, "R8 no repeat pulse", done, 0);
    end
    run(16'sd100, -16'sd50, 16'sd17, -16'sd4, 16'sd90, 1'b0, "negstep R4");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule